// File: doc/BRIEF.md
# Serial Grid Loader and Frame Dumper

This unit sits between a host serial link and the two-segment grid memory of a cellular automaton engine. Before the simulation starts, it receives the initial grid over an 8N1 serial line, unpacks each received byte into one or two cells and writes them into segment 0 in raster order from address 0. When the last cell has been stored it raises a load-done flag. The engine waits for this flag before it starts running.

Later, a dump request makes the unit read the frame that is currently on screen back out of memory. The request input names that segment. The unit packs the cells into bytes the same way as on load and sends them to the host over the same line. A one-cycle done pulse marks the end of the transfer. The cell width is a parameter. With 4-bit cells a byte holds two cells, the earlier cell in the high nibble. With 8-bit cells a byte holds exactly one cell. The bit period is the clock rate divided by the baud rate (2 Mbaud by default).

Top module: `grid_serial_loader`

## Requirements
- R1: While reset is held low, and after it is released with no traffic, tx_line is high, load_done is 0, and mem_we and mem_re are 0.
- R2: Both serial directions use 8N1 framing, least significant bit first, with a bit period of CLK_HZ/BAUD clock cycles (100 cycles at the defaults). A frame is a low start bit, 8 data bits and a high stop bit.
- R3: With CELL_W = 8, every received byte is written as one cell. Addresses are consecutive from 0, and the segment bit (the address MSB) is 0. On dump, every cell is sent as one byte.
- R4: With CELL_W = 4, a received byte b is written as two cells: b[7:4] at address n and then b[3:0] at address n+1, on consecutive cycles.
- R5: load_done is 0 until the write of cell GRID_CELLS-1. It rises in the clock cycle right after that write and then stays high. Bytes received after that cause no memory write.
- R6: A one-cycle dump_req pulse, given while load_done is 1 and no dump is running, reads all GRID_CELLS cells in address order from the segment that shown_seg held in the request cycle. A later change of shown_seg does not affect that dump. The cells are sent packed as in R3 or R4.
- R7: dump_done is a one-cycle pulse, given once per dump after the stop bit of the last byte has been fully sent. The line is high at that point.
- R8: A dump_req pulse while a dump is running is ignored: no extra bytes are sent and no extra dump_done pulse is given.
- R9: A dump_req pulse while load_done is 0 is ignored: nothing is sent and no dump_done pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Serial input from the host, idle high |
| tx_line | output | 1 | Serial output to the host, idle high |
| shown_seg | input | 1 | Memory segment currently being displayed |
| dump_req | input | 1 | Pulse that requests a frame dump |
| dump_done | output | 1 | One-cycle pulse at the end of a dump |
| load_done | output | 1 | High once the whole grid has been loaded |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | $clog2(GRID_CELLS)+1 | Write address, MSB is the segment |
| mem_wdata | output | CELL_W | Cell value to write |
| mem_re | output | 1 | Memory read strobe; data is due one cycle later |
| mem_raddr | output | $clog2(GRID_CELLS)+1 | Read address, MSB is the segment |
| mem_rdata | input | CELL_W | Cell value read from memory |

## Verification
The embedded properties check on every cycle that:
- no write occurs once loading has finished;
- write and read addresses stay inside the grid;
- nibble writes come in address-consecutive pairs;
- a byte offered to the transmitter is held until it is taken;
- every transmitted frame begins with a low start bit;
- the done pulse only comes with an idle transmitter.

Only the scenarios can show the rest:
- the nibble order and the cell-per-byte order;
- the exact cycle in which load_done rises;
- that the segment is latched at the request;
- that requests before the load or during a dump have no visible effect on the line.

// File: rtl/grid_xfer_pkg.sv
package grid_xfer_pkg;

   function automatic int cells_per_byte(input int cell_w);
      return 8 / cell_w;
   endfunction

   typedef enum logic [1:0] {
      RS_IDLE,
      RS_START,
      RS_DATA,
      RS_STOP
   } rx_state_e;

   typedef enum logic [2:0] {
      DS_IDLE,
      DS_READ,
      DS_CAP,
      DS_SEND,
      DS_DRAIN
   } dump_state_e;

endpackage

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
   parameter int BIT_CYC = 100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_i,
   output logic       byte_valid,
   output logic [7:0] byte_data
);
   import grid_xfer_pkg::*;

   localparam int CW   = $clog2(BIT_CYC + 1);
   localparam int HALF = BIT_CYC / 2;

   logic [1:0]  sync_q;
   rx_state_e   state_q;
   logic [CW-1:0] cnt_q;
   logic [2:0]  bit_q;
   logic [7:0]  shift_q;
   logic        rx_s;

   assign rx_s = sync_q[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q     <= 2'b11;
         state_q    <= RS_IDLE;
         cnt_q      <= '0;
         bit_q      <= '0;
         shift_q    <= '0;
         byte_valid <= 1'b0;
         byte_data  <= '0;
      end else begin
         sync_q     <= {sync_q[0], line_i};
         byte_valid <= 1'b0;
         case (state_q)
            RS_IDLE: begin
               cnt_q <= '0;
               if (!rx_s) state_q <= RS_START;
            end
            RS_START: begin
               if (cnt_q == CW'(HALF - 1)) begin
                  cnt_q   <= '0;
                  bit_q   <= '0;
                  state_q <= rx_s ? RS_IDLE : RS_DATA;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            RS_DATA: begin
               if (cnt_q == CW'(BIT_CYC - 1)) begin
                  cnt_q   <= '0;
                  shift_q <= {rx_s, shift_q[7:1]};
                  if (bit_q == 3'd7) state_q <= RS_STOP;
                  else               bit_q   <= bit_q + 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               if (cnt_q == CW'(BIT_CYC - 1)) begin
                  cnt_q      <= '0;
                  state_q    <= RS_IDLE;
                  byte_valid <= rx_s;
                  byte_data  <= shift_q;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         endcase
      end
   end

   // R2
   rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |=> !byte_valid);

endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core #(
   parameter int BIT_CYC = 100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       byte_valid,
   input  logic [7:0] byte_data,
   output logic       byte_ready,
   output logic       line_o
);
   localparam int CW = $clog2(BIT_CYC + 1);

   logic          busy_q;
   logic [9:0]    frame_q;
   logic [3:0]    bit_q;
   logic [CW-1:0] cnt_q;

   assign byte_ready = !busy_q;
   assign line_o     = busy_q ? frame_q[0] : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         frame_q <= '1;
         bit_q   <= '0;
         cnt_q   <= '0;
      end else if (!busy_q) begin
         if (byte_valid) begin
            busy_q  <= 1'b1;
            frame_q <= {1'b1, byte_data, 1'b0};
            bit_q   <= '0;
            cnt_q   <= '0;
         end
      end else if (cnt_q == CW'(BIT_CYC - 1)) begin
         cnt_q <= '0;
         if (bit_q == 4'd9) begin
            busy_q <= 1'b0;
         end else begin
            frame_q <= {1'b1, frame_q[9:1]};
            bit_q   <= bit_q + 1'b1;
         end
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R2
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> !line_o);

endmodule

// File: rtl/grid_load_ctrl.sv
module grid_load_ctrl #(
   parameter int CELL_W     = 4,
   parameter int GRID_CELLS = 16,
   parameter int AW         = $clog2(GRID_CELLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_valid,
   input  logic [7:0]        byte_data,
   output logic              we,
   output logic [AW-1:0]     waddr,
   output logic [CELL_W-1:0] wdata,
   output logic              done
);
   import grid_xfer_pkg::*;

   localparam int CPB = cells_per_byte(CELL_W);
   localparam logic [AW-1:0] LAST = AW'(GRID_CELLS - 1);

   logic [AW-1:0] ptr_q;
   logic          fin_q;

   always_ff @(posedge clk) begin
      if (!rst_n) done <= 1'b0;
      else        done <= fin_q;
   end

   generate
      if (CPB == 1) begin : g_whole
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               we    <= 1'b0;
               waddr <= '0;
               wdata <= '0;
               ptr_q <= '0;
               fin_q <= 1'b0;
            end else begin
               we <= 1'b0;
               if (byte_valid && !fin_q) begin
                  we    <= 1'b1;
                  waddr <= ptr_q;
                  wdata <= byte_data[CELL_W-1:0];
                  ptr_q <= ptr_q + 1'b1;
                  if (ptr_q == LAST) fin_q <= 1'b1;
               end
            end
         end
      end else begin : g_split
         logic             lo_pend_q;
         logic [CELL_W-1:0] lo_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               we        <= 1'b0;
               waddr     <= '0;
               wdata     <= '0;
               ptr_q     <= '0;
               fin_q     <= 1'b0;
               lo_pend_q <= 1'b0;
               lo_q      <= '0;
            end else begin
               we <= 1'b0;
               if (lo_pend_q) begin
                  we        <= 1'b1;
                  waddr     <= ptr_q;
                  wdata     <= lo_q;
                  ptr_q     <= ptr_q + 1'b1;
                  lo_pend_q <= 1'b0;
                  if (ptr_q == LAST) fin_q <= 1'b1;
               end else if (byte_valid && !fin_q) begin
                  we        <= 1'b1;
                  waddr     <= ptr_q;
                  wdata     <= byte_data[7:8-CELL_W];
                  lo_q      <= byte_data[CELL_W-1:0];
                  ptr_q     <= ptr_q + 1'b1;
                  lo_pend_q <= 1'b1;
               end
            end
         end

         // R4
         pair_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we && $past(we)) |-> (waddr == $past(waddr) + 1'b1));
      end
   endgenerate

   // R5
   no_write_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !we);

   // R3
   waddr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (int'(waddr) < GRID_CELLS));

endmodule

// File: rtl/grid_dump_ctrl.sv
module grid_dump_ctrl #(
   parameter int CELL_W     = 4,
   parameter int GRID_CELLS = 16,
   parameter int AW         = $clog2(GRID_CELLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              loaded,
   input  logic              shown_seg,
   output logic              re,
   output logic [AW:0]       raddr,
   input  logic [CELL_W-1:0] rdata,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   input  logic              tx_ready,
   output logic              done
);
   import grid_xfer_pkg::*;

   localparam int CPB = cells_per_byte(CELL_W);
   localparam int KW  = (CPB > 1) ? $clog2(CPB) : 1;
   localparam logic [AW-1:0] LAST = AW'(GRID_CELLS - 1);

   dump_state_e   state_q;
   logic          seg_q;
   logic [AW-1:0] ptr_q;
   logic [KW-1:0] k_q;
   logic          last_q;
   logic [7:0]    pack_q;
   logic [7:0]    pack_d;

   generate
      if (CPB == 1) begin : g_whole
         assign pack_d = 8'(rdata);
      end else begin : g_pack
         assign pack_d = {pack_q[7-CELL_W:0], rdata};
      end
   endgenerate

   assign re       = (state_q == DS_READ);
   assign raddr    = {seg_q, ptr_q};
   assign tx_valid = (state_q == DS_SEND);
   assign tx_data  = pack_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= DS_IDLE;
         seg_q   <= 1'b0;
         ptr_q   <= '0;
         k_q     <= '0;
         last_q  <= 1'b0;
         pack_q  <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state_q)
            DS_IDLE: begin
               if (req && loaded) begin
                  seg_q   <= shown_seg;
                  ptr_q   <= '0;
                  k_q     <= '0;
                  state_q <= DS_READ;
               end
            end
            DS_READ: state_q <= DS_CAP;
            DS_CAP: begin
               pack_q <= pack_d;
               ptr_q  <= ptr_q + 1'b1;
               last_q <= (ptr_q == LAST);
               if (k_q == KW'(CPB - 1)) begin
                  state_q <= DS_SEND;
               end else begin
                  k_q     <= k_q + 1'b1;
                  state_q <= DS_READ;
               end
            end
            DS_SEND: begin
               if (tx_ready) begin
                  k_q     <= '0;
                  state_q <= last_q ? DS_DRAIN : DS_READ;
               end
            end
            default: begin
               if (tx_ready) begin
                  done    <= 1'b1;
                  state_q <= DS_IDLE;
               end
            end
         endcase
      end
   end

   // R6
   raddr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      re |-> (int'(raddr[AW-1:0]) < GRID_CELLS));

   // R2
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> tx_ready);

endmodule

// File: rtl/grid_serial_loader.sv
module grid_serial_loader #(
   parameter int CELL_W     = 4,
   parameter int GRID_CELLS = 16,
   parameter int CLK_HZ     = 200_000_000,
   parameter int BAUD       = 2_000_000
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          rx_line,
   output logic                          tx_line,
   input  logic                          shown_seg,
   input  logic                          dump_req,
   output logic                          dump_done,
   output logic                          load_done,
   output logic                          mem_we,
   output logic [$clog2(GRID_CELLS):0]   mem_waddr,
   output logic [CELL_W-1:0]             mem_wdata,
   output logic                          mem_re,
   output logic [$clog2(GRID_CELLS):0]   mem_raddr,
   input  logic [CELL_W-1:0]             mem_rdata
);
   import grid_xfer_pkg::*;

   localparam int AW      = $clog2(GRID_CELLS);
   localparam int BIT_CYC = CLK_HZ / BAUD;
   localparam int CPB     = cells_per_byte(CELL_W);

   initial begin
      cell_w_ok: assert (CELL_W == 4 || CELL_W == 8)
         else $error("CELL_W must be 4 or 8");
      grid_ok: assert (GRID_CELLS >= 2 && (GRID_CELLS % CPB) == 0)
         else $error("GRID_CELLS must be >= 2 and a multiple of cells per byte");
      baud_ok: assert (BIT_CYC >= 4)
         else $error("clock too slow for baud rate");
   end

   logic          rx_valid;
   logic [7:0]    rx_byte;
   logic          tx_valid;
   logic [7:0]    tx_byte;
   logic          tx_ready;
   logic [AW-1:0] wa_cell;

   serial_rx_core #(.BIT_CYC(BIT_CYC)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_i     (rx_line),
      .byte_valid (rx_valid),
      .byte_data  (rx_byte)
   );

   grid_load_ctrl #(.CELL_W(CELL_W), .GRID_CELLS(GRID_CELLS), .AW(AW)) u_load (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_valid (rx_valid),
      .byte_data  (rx_byte),
      .we         (mem_we),
      .waddr      (wa_cell),
      .wdata      (mem_wdata),
      .done       (load_done)
   );

   assign mem_waddr = {1'b0, wa_cell};

   grid_dump_ctrl #(.CELL_W(CELL_W), .GRID_CELLS(GRID_CELLS), .AW(AW)) u_dump (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (dump_req),
      .loaded    (load_done),
      .shown_seg (shown_seg),
      .re        (mem_re),
      .raddr     (mem_raddr),
      .rdata     (mem_rdata),
      .tx_valid  (tx_valid),
      .tx_data   (tx_byte),
      .tx_ready  (tx_ready),
      .done      (dump_done)
   );

   serial_tx_core #(.BIT_CYC(BIT_CYC)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_valid (tx_valid),
      .byte_data  (tx_byte),
      .byte_ready (tx_ready),
      .line_o     (tx_line)
   );

   // R9
   no_read_before_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |-> load_done);

endmodule

// File: tb/grid_serial_loader_test.sv
module grid_serial_loader_test;

   localparam int GC  = 16;
   localparam int BIT = 100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic       rx4 = 1'b1, rx8 = 1'b1;
   logic       tx4, tx8;
   logic       seg_sel = 1'b0;
   logic       dreq4 = 1'b0, dreq8 = 1'b0;
   logic       ddone4, ddone8, ld4, ld8;
   logic       we4, we8, re4, re8;
   logic [4:0] wa4, wa8, ra4, ra8;
   logic [3:0] wd4, rd4;
   logic [7:0] wd8, rd8;

   logic       pl_en = 1'b0;
   logic [4:0] pl_a = '0;
   logic [3:0] pl_d4 = '0;
   logic [7:0] pl_d8 = '0;
   logic [3:0] mem4 [32];
   logic [7:0] mem8 [32];

   int checks = 0, errors = 0;
   int wr_cnt4 = 0, wr_cnt8 = 0, tx_cnt4 = 0, tx_cnt8 = 0;
   int done_cnt4 = 0, done_cnt8 = 0;
   bit finished = 1'b0;
   int exp_wr4 [$];
   int exp_wr8 [$];
   int exp_tx4 [$];
   int exp_tx8 [$];
   logic [7:0] img4 [8];
   logic [7:0] img8 [16];

   grid_serial_loader #(.CELL_W(4), .GRID_CELLS(GC)) uut (
      .clk(clk), .rst_n(rst_n), .rx_line(rx4), .tx_line(tx4),
      .shown_seg(seg_sel), .dump_req(dreq4), .dump_done(ddone4),
      .load_done(ld4), .mem_we(we4), .mem_waddr(wa4), .mem_wdata(wd4),
      .mem_re(re4), .mem_raddr(ra4), .mem_rdata(rd4));

   grid_serial_loader #(.CELL_W(8), .GRID_CELLS(GC)) uut_w8 (
      .clk(clk), .rst_n(rst_n), .rx_line(rx8), .tx_line(tx8),
      .shown_seg(seg_sel), .dump_req(dreq8), .dump_done(ddone8),
      .load_done(ld8), .mem_we(we8), .mem_waddr(wa8), .mem_wdata(wd8),
      .mem_re(re8), .mem_raddr(ra8), .mem_rdata(rd8));

   always @(posedge clk) begin
      if (we4) mem4[wa4] <= wd4;
      if (we8) mem8[wa8] <= wd8;
      if (pl_en) begin
         mem4[pl_a] <= pl_d4;
         mem8[pl_a] <= pl_d8;
      end
      if (re4) rd4 <= mem4[ra4];
      if (re8) rd8 <= mem8[ra8];
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic finish_sim();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // scoreboard monitors for memory writes (R3, R4, R5)
   bit last4_seen = 1'b0, last8_seen = 1'b0;
   always @(negedge clk) begin
      if (last4_seen) begin
         check(ld4 == 1'b1, "R5 load_done rise w4", int'(ld4), 1);
         last4_seen = 1'b0;
      end
      if (last8_seen) begin
         check(ld8 == 1'b1, "R5 load_done rise w8", int'(ld8), 1);
         last8_seen = 1'b0;
      end
      if (rst_n && we4) begin
         wr_cnt4++;
         if (exp_wr4.size() == 0) check(1'b0, "R4 unexpected write", int'({wa4, wd4}), -1);
         else begin
            int e;
            e = exp_wr4.pop_front();
            check(int'({wa4, 4'b0, wd4}) == e, "R4 nibble write", int'({wa4, 4'b0, wd4}), e);
         end
         if (wa4 == 5'd15) begin
            check(ld4 == 1'b0, "R5 load_done early w4", int'(ld4), 0);
            last4_seen = 1'b1;
         end
      end
      if (rst_n && we8) begin
         wr_cnt8++;
         if (exp_wr8.size() == 0) check(1'b0, "R3 unexpected write", int'({wa8, wd8}), -1);
         else begin
            int e;
            e = exp_wr8.pop_front();
            check(int'({wa8, wd8}) == e, "R3 byte write", int'({wa8, wd8}), e);
         end
         if (wa8 == 5'd15) begin
            check(ld8 == 1'b0, "R5 load_done early w8", int'(ld8), 0);
            last8_seen = 1'b1;
         end
      end
      if (rst_n && ddone4) begin
         done_cnt4++;
         check(exp_tx4.size() == 0 && tx4, "R7 done after last byte w4", exp_tx4.size(), 0);
      end
      if (rst_n && ddone8) begin
         done_cnt8++;
         check(exp_tx8.size() == 0 && tx8, "R7 done after last byte w8", exp_tx8.size(), 0);
      end
   end

   function automatic logic line_of(input int lane);
      return (lane == 0) ? tx4 : tx8;
   endfunction

   // R2: decode one frame whose start bit was just seen
   task automatic grab(input int lane);
      logic [7:0] b;
      logic sb;
      int e;
      repeat (BIT + BIT / 2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         b[i] = line_of(lane);
         repeat (BIT) @(negedge clk);
      end
      sb = line_of(lane);
      check(sb == 1'b1, "R2 stop bit", int'(sb), 1);
      if (lane == 0) begin
         tx_cnt4++;
         if (exp_tx4.size() == 0) check(1'b0, "R8 unexpected tx byte w4", int'(b), -1);
         else begin
            e = exp_tx4.pop_front();
            check(int'(b) == e, "R6 dump byte w4 (R4 packing)", int'(b), e);
         end
      end else begin
         tx_cnt8++;
         if (exp_tx8.size() == 0) check(1'b0, "R8 unexpected tx byte w8", int'(b), -1);
         else begin
            e = exp_tx8.pop_front();
            check(int'(b) == e, "R6 dump byte w8 (R3 packing)", int'(b), e);
         end
      end
   endtask

   initial begin : tx_mon4
      forever begin
         @(negedge clk);
         if (rst_n && !tx4) grab(0);
      end
   end

   initial begin : tx_mon8
      forever begin
         @(negedge clk);
         if (rst_n && !tx8) grab(1);
      end
   end

   task automatic send(input int lane, input logic [7:0] b);
      logic [9:0] f;
      f = {1'b1, b, 1'b0};
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (lane == 0) rx4 = f[i];
         else           rx8 = f[i];
         repeat (BIT - 1) @(negedge clk);
      end
   endtask

   task automatic pulse_req(input int lane);
      @(negedge clk);
      if (lane == 0) dreq4 = 1'b1; else dreq8 = 1'b1;
      @(negedge clk);
      dreq4 = 1'b0;
      dreq8 = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      finish_sim();
   end

   initial begin : driver
      repeat (5) @(negedge clk);
      // R1 during reset
      check(tx4 && tx8, "R1 tx idle in reset", int'({tx4, tx8}), 3);
      check(!ld4 && !ld8, "R1 load_done low in reset", int'({ld4, ld8}), 0);
      check(!we4 && !we8 && !re4 && !re8, "R1 no strobes in reset",
            int'({we4, we8, re4, re8}), 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      check(tx4 && tx8 && !ld4 && !ld8, "R1 idle after reset", int'({tx4, tx8, ld4, ld8}), 12);

      // R9: request before load
      pulse_req(0);
      pulse_req(1);
      repeat (3000) @(negedge clk);
      check(done_cnt4 == 0 && done_cnt8 == 0, "R9 no done before load",
            done_cnt4 + done_cnt8, 0);
      check(tx_cnt4 == 0 && tx_cnt8 == 0, "R9 no bytes before load", tx_cnt4 + tx_cnt8, 0);

      // R4 load, 4-bit cells
      for (int i = 0; i < 8; i++) begin
         img4[i] = 8'(8'h1e + i * 37);
         exp_wr4.push_back((2 * i) * 256 + int'(img4[i][7:4]));
         exp_wr4.push_back((2 * i + 1) * 256 + int'(img4[i][3:0]));
      end
      for (int i = 0; i < 8; i++) send(0, img4[i]);
      repeat (200) @(negedge clk);
      check(ld4 == 1'b1, "R5 load_done held w4", int'(ld4), 1);
      check(wr_cnt4 == 16 && exp_wr4.size() == 0, "R4 write count", wr_cnt4, 16);

      // R3 load, 8-bit cells
      for (int i = 0; i < 16; i++) begin
         img8[i] = 8'(i * 29 + 3);
         exp_wr8.push_back(i * 256 + int'(img8[i]));
      end
      for (int i = 0; i < 16; i++) send(1, img8[i]);
      repeat (200) @(negedge clk);
      check(ld8 == 1'b1, "R5 load_done held w8", int'(ld8), 1);
      check(wr_cnt8 == 16 && exp_wr8.size() == 0, "R3 write count", wr_cnt8, 16);

      // R5: extra bytes are ignored
      send(0, 8'ha5);
      send(1, 8'h5a);
      repeat (300) @(negedge clk);
      check(wr_cnt4 == 16 && wr_cnt8 == 16, "R5 no write after load", wr_cnt4 + wr_cnt8, 32);
      check(ld4 && ld8, "R5 load_done stays", int'({ld4, ld8}), 3);

      // R6 dump of segment 0, with R8 second request mid-transfer
      seg_sel = 1'b0;
      for (int i = 0; i < 8; i++) exp_tx4.push_back(int'(img4[i]));
      pulse_req(0);
      repeat (2500) @(negedge clk);
      pulse_req(0);
      while (done_cnt4 < 1) @(negedge clk);
      repeat (3000) @(negedge clk);
      check(tx_cnt4 == 8, "R8 byte count w4", tx_cnt4, 8);
      check(done_cnt4 == 1, "R8 single done w4", done_cnt4, 1);

      // fill segment 1 with a distinct pattern
      for (int j = 0; j < 16; j++) begin
         @(negedge clk);
         pl_en = 1'b1;
         pl_a  = 5'(16 + j);
         pl_d4 = 4'(15 - j);
         pl_d8 = 8'(8'hc3 ^ (j * 11));
      end
      @(negedge clk);
      pl_en = 1'b0;

      // R6: segment latched at request, w4
      for (int k = 0; k < 8; k++)
         exp_tx4.push_back(int'({4'(15 - 2 * k), 4'(14 - 2 * k)}));
      seg_sel = 1'b1;
      pulse_req(0);
      seg_sel = 1'b0;
      while (done_cnt4 < 2) @(negedge clk);
      repeat (50) @(negedge clk);
      check(tx_cnt4 == 16 && exp_tx4.size() == 0, "R6 seg1 dump w4", tx_cnt4, 16);

      // R6/R3: segment 1 dump, w8
      for (int j = 0; j < 16; j++) exp_tx8.push_back(int'(8'(8'hc3 ^ (j * 11))));
      seg_sel = 1'b1;
      pulse_req(1);
      seg_sel = 1'b0;
      while (done_cnt8 < 1) @(negedge clk);
      repeat (50) @(negedge clk);
      check(tx_cnt8 == 16 && exp_tx8.size() == 0, "R6 seg1 dump w8", tx_cnt8, 16);
      check(done_cnt8 == 1, "R7 single done w8", done_cnt8, 1);

      finish_sim();
   end

endmodule